// File: doc/BRIEF.md
# Bilateral Bit-Level Systolic Chain

This block is a one-dimensional chain of identical single-bit processing cells. Two registered data streams travel through it in opposite directions, one cell per clock. Every cell looks at three bits. The first is the bit arriving from its left neighbour. The second is the bit arriving from its right neighbour. The third is a vertical bit that is driven from outside on every cycle. From these three bits the cell computes two outputs through two fixed Boolean truth tables, one output for each direction, and latches both on the next clock edge.

All cells share the same two truth tables, which are set by parameters. The only way into the chain at its two ends is the leftmost cell's left input and the rightmost cell's right input. The only outputs seen outside are the leftmost cell's left-going latch and the rightmost cell's right-going latch.

The chain advances on every clock and has no stall. A per-cycle valid/ready handshake would break the fixed one-cell-per-cycle timing that the stream relationships depend on, so the edges are plain bits. A synchronous reset clears every latch.

Top module: `sysarr_top`

## Requirements
- R1: Each cell forms a 3-bit index {W, X, Y}, with W (the bit from the left) as the MSB and Y (the vertical bit) as the LSB. One cycle later its left-going latch holds bit [index] of F_TBL.
- R2: With the same index, the cell's right-going latch holds bit [index] of G_TBL one cycle later.
- R3: The left-going latch of cell i is the X input of cell i-1, and the right-going latch of cell i is the W input of cell i+1. Both streams move exactly one cell per clock.
- R4: Cell 0 takes its W input from port in_w. Cell N_CELLS-1 takes its X input from port in_x.
- R5: out_l is the left-going latch of cell 0 and out_r is the right-going latch of cell N_CELLS-1. No other cell output is visible at the ports.
- R6: While rst is high at a rising edge, every latch is cleared, so out_l and out_r read 0 after that edge whatever the other inputs are.
- R7: Bit i of vert is the Y input of cell i on every cycle.
- R8: With F_TBL = 8'hCC (left output copies X) and G_TBL = 8'hF0 (right output copies W), a one-cycle pulse on in_w reaches out_r N_CELLS edges later, and a pulse on in_x reaches out_l N_CELLS edges later.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock shared by all cells |
| rst | input | 1 | Synchronous reset, active high, clears all latches |
| in_w | input | 1 | Left input (W) of cell 0 |
| in_x | input | 1 | Right input (X) of cell N_CELLS-1 |
| vert | input | N_CELLS | Vertical inputs, bit i goes to cell i |
| out_l | output | 1 | Left-going latch of cell 0 |
| out_r | output | 1 | Right-going latch of cell N_CELLS-1 |

## Verification
A wrong latch inside cell i is only seen at the ports once it has propagated through the cells between it and an edge. That takes up to i cycles to reach out_l and up to N_CELLS-1-i cycles to reach out_r. It can also be masked on the way if a cell further along is insensitive to that input. For this reason the bench drives many patterns on the vertical bus and the edge inputs, so that most paths stay sensitive, and it compares both edge outputs with a full behavioural model on every cycle. A second instance configured as pure delays makes a fault in the wiring direction or the latency show up exactly N_CELLS cycles after a single pulse.

// File: rtl/sysarr_pkg.sv
package sysarr_pkg;

  // Truth table of a 3-input Boolean function, indexed by {w,x,y}.
  typedef logic [7:0] lut8_t;

  // Input bits of one cell. Bit order matters: w is the MSB of the index.
  typedef struct packed {
    logic w;
    logic x;
    logic y;
  } cell_in_t;

  function automatic logic [2:0] cell_index(cell_in_t s);
    return {s.w, s.x, s.y};
  endfunction

endpackage

// File: rtl/sysarr_lut.sv
module sysarr_lut
  import sysarr_pkg::*;
#(
  parameter lut8_t TABLE = 8'h00
) (
  input  cell_in_t sel,
  output logic     bit_o
);

  logic [2:0] idx;

  always_comb begin
    idx   = cell_index(sel);
    bit_o = TABLE[idx];
  end

endmodule

// File: rtl/sysarr_cell.sv
module sysarr_cell
  import sysarr_pkg::*;
#(
  parameter lut8_t F_TBL = 8'h96,
  parameter lut8_t G_TBL = 8'hE8
) (
  input  logic clk,
  input  logic rst,
  input  logic w_i,
  input  logic x_i,
  input  logic y_i,
  output logic l_q,
  output logic r_q
);

  cell_in_t st;
  logic     l_d;
  logic     r_d;

  assign st = '{w: w_i, x: x_i, y: y_i};

  sysarr_lut #(.TABLE(F_TBL)) u_f (.sel(st), .bit_o(l_d));
  sysarr_lut #(.TABLE(G_TBL)) u_g (.sel(st), .bit_o(r_d));

  always_ff @(posedge clk) begin
    if (rst) begin
      l_q <= 1'b0;
      r_q <= 1'b0;
    end else begin
      l_q <= l_d;
      r_q <= r_d;
    end
  end

endmodule

// File: rtl/sysarr_top.sv
module sysarr_top
  import sysarr_pkg::*;
#(
  parameter int    N_CELLS = 8,
  parameter lut8_t F_TBL   = 8'h96,
  parameter lut8_t G_TBL   = 8'hE8
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               in_w,
  input  logic               in_x,
  input  logic [N_CELLS-1:0] vert,
  output logic               out_l,
  output logic               out_r
);

  localparam int LAST = N_CELLS - 1;

  logic [N_CELLS-1:0] w_bus;
  logic [N_CELLS-1:0] x_bus;
  logic [N_CELLS-1:0] lft_q;
  logic [N_CELLS-1:0] rgt_q;

  for (genvar i = 0; i < N_CELLS; i++) begin : g_cell
    // Rightward stream: W of cell i.
    if (i == 0) begin : g_wl
      assign w_bus[i] = in_w;
    end else begin : g_wi
      assign w_bus[i] = rgt_q[i-1];
    end
    // Leftward stream: X of cell i.
    if (i == LAST) begin : g_xr
      assign x_bus[i] = in_x;
    end else begin : g_xi
      assign x_bus[i] = lft_q[i+1];
    end

    sysarr_cell #(.F_TBL(F_TBL), .G_TBL(G_TBL)) u_cell (
      .clk (clk),
      .rst (rst),
      .w_i (w_bus[i]),
      .x_i (x_bus[i]),
      .y_i (vert[i]),
      .l_q (lft_q[i]),
      .r_q (rgt_q[i])
    );
  end

  assign out_l = lft_q[0];
  assign out_r = rgt_q[LAST];

endmodule

// File: rtl/sysarr_chk.sv
module sysarr_chk
  import sysarr_pkg::*;
#(
  parameter int    N_CELLS = 8,
  parameter lut8_t F_TBL   = 8'h96,
  parameter lut8_t G_TBL   = 8'hE8
) (
  input logic               clk,
  input logic               rst,
  input logic               in_w,
  input logic               in_x,
  input logic [N_CELLS-1:0] vert,
  input logic [N_CELLS-1:0] lft_q,
  input logic [N_CELLS-1:0] rgt_q,
  input logic               out_l,
  input logic               out_r
);

  localparam int LAST = N_CELLS - 1;

  // R6: a reset edge empties every latch.
  assert_reset_clear_R6: assert property (@(posedge clk)
    rst |=> (lft_q == '0 && rgt_q == '0 && out_l == 1'b0 && out_r == 1'b0));

  for (genvar i = 0; i < N_CELLS; i++) begin : g_prop
    if (i == 0) begin : g_left_end
      // R4 with R1 and R7: cell 0 reads in_w as W.
      assert_edge_w_left_R4: assert property (@(posedge clk) disable iff (rst)
        !rst |=> lft_q[i] == F_TBL[{$past(in_w), $past(lft_q[i+1]), $past(vert[i])}]);
      assert_edge_w_right_R4: assert property (@(posedge clk) disable iff (rst)
        !rst |=> rgt_q[i] == G_TBL[{$past(in_w), $past(lft_q[i+1]), $past(vert[i])}]);
    end else if (i == LAST) begin : g_right_end
      // R4: the last cell reads in_x as X.
      assert_edge_x_left_R4: assert property (@(posedge clk) disable iff (rst)
        !rst |=> lft_q[i] == F_TBL[{$past(rgt_q[i-1]), $past(in_x), $past(vert[i])}]);
      assert_edge_x_right_R4: assert property (@(posedge clk) disable iff (rst)
        !rst |=> rgt_q[i] == G_TBL[{$past(rgt_q[i-1]), $past(in_x), $past(vert[i])}]);
    end else begin : g_mid
      // R1 and R3: the left function over neighbour latches.
      assert_left_fn_R1: assert property (@(posedge clk) disable iff (rst)
        !rst |=> lft_q[i] == F_TBL[{$past(rgt_q[i-1]), $past(lft_q[i+1]), $past(vert[i])}]);
      // R2 and R3: the right function over neighbour latches.
      assert_right_fn_R2: assert property (@(posedge clk) disable iff (rst)
        !rst |=> rgt_q[i] == G_TBL[{$past(rgt_q[i-1]), $past(lft_q[i+1]), $past(vert[i])}]);
    end
  end

endmodule

bind sysarr_top sysarr_chk #(
  .N_CELLS(N_CELLS),
  .F_TBL  (F_TBL),
  .G_TBL  (G_TBL)
) u_chk (
  .clk   (clk),
  .rst   (rst),
  .in_w  (in_w),
  .in_x  (in_x),
  .vert  (vert),
  .lft_q (lft_q),
  .rgt_q (rgt_q),
  .out_l (out_l),
  .out_r (out_r)
);

// File: tb/sysarr_top_test.sv
`timescale 1ns/100ps
module sysarr_top_test;

  localparam int        N  = 8;
  localparam logic [7:0] FA = 8'h96;  // left = parity of W,X,Y
  localparam logic [7:0] GA = 8'hE8;  // right = majority of W,X,Y
  localparam logic [7:0] FB = 8'hCC;  // left copies X
  localparam logic [7:0] GB = 8'hF0;  // right copies W

  logic         clk  = 1'b0;
  logic         rst  = 1'b1;
  logic         in_w = 1'b0;
  logic         in_x = 1'b0;
  logic [N-1:0] vert = '0;
  logic         a_l, a_r, b_l, b_r;

  always #2.5 clk = ~clk;

  sysarr_top #(.N_CELLS(N), .F_TBL(FA), .G_TBL(GA)) uut (
    .clk(clk), .rst(rst), .in_w(in_w), .in_x(in_x), .vert(vert),
    .out_l(a_l), .out_r(a_r));

  sysarr_top #(.N_CELLS(N), .F_TBL(FB), .G_TBL(GB)) uut_dly (
    .clk(clk), .rst(rst), .in_w(in_w), .in_x(in_x), .vert(vert),
    .out_l(b_l), .out_r(b_r));

  int    checks = 0;
  int    bad    = 0;
  bit    done   = 0;
  string tag    = "R6";
  bit    ml[2][N];
  bit    mr[2][N];

  task automatic step_model(int k, logic [7:0] f, logic [7:0] g);
    bit nl[N];
    bit nr[N];
    for (int i = 0; i < N; i++) begin
      int w, x, idx;
      w   = (i == 0)     ? int'(in_w) : int'(mr[k][i-1]);
      x   = (i == N - 1) ? int'(in_x) : int'(ml[k][i+1]);
      idx = w * 4 + x * 2 + int'(vert[i]);
      nl[i] = rst ? 1'b0 : f[idx];
      nr[i] = rst ? 1'b0 : g[idx];
    end
    for (int i = 0; i < N; i++) begin
      ml[k][i] = nl[i];
      mr[k][i] = nr[i];
    end
  endtask

  task automatic cmp(string t, string what, logic act, bit exp);
    checks++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s actual=%0b expected=%0b at %0t", t, what, act, exp, $time);
    end
  endtask

  task automatic cycle();
    @(posedge clk);
    step_model(0, FA, GA);
    step_model(1, FB, GB);
    @(negedge clk);
    cmp(tag, "uut.out_l",     a_l, ml[0][0]);
    cmp(tag, "uut.out_r",     a_r, mr[0][N-1]);
    cmp(tag, "uut_dly.out_l", b_l, ml[1][0]);
    cmp(tag, "uut_dly.out_r", b_r, mr[1][N-1]);
  endtask

  initial begin
    // R6: reset held with busy inputs.
    tag = "R6";
    for (int c = 0; c < 3; c++) begin
      in_w = 1'($urandom); in_x = 1'($urandom); vert = N'($urandom);
      cycle();
    end
    rst = 1'b0;

    // R7: only the vertical bus moves (walking one, then random).
    tag = "R7 R1 R2";
    in_w = 1'b0; in_x = 1'b0;
    for (int c = 0; c < 40; c++) begin
      vert = (c < 2 * N) ? N'(1 << (c % N)) : N'($urandom);
      cycle();
    end

    // R1 R2 R3: everything random.
    tag = "R1 R2 R3";
    for (int c = 0; c < 600; c++) begin
      in_w = 1'($urandom); in_x = 1'($urandom); vert = N'($urandom);
      cycle();
    end

    // R4 R5: only the edge inputs move.
    tag = "R4 R5";
    vert = '0;
    for (int c = 0; c < 100; c++) begin
      in_w = 1'($urandom); in_x = 1'($urandom);
      cycle();
    end

    // R6: a reset in the middle of traffic.
    tag = "R6";
    in_w = 1'b1; in_x = 1'b1; vert = '1;
    rst = 1'b1;
    cycle();
    rst = 1'b0;
    tag = "R1 R2 R6";
    for (int c = 0; c < 20; c++) begin
      in_w = 1'($urandom); in_x = 1'($urandom); vert = N'($urandom);
      cycle();
    end

    // R8: pulse latency through the delay configuration.
    tag = "R8";
    in_w = 1'b0; in_x = 1'b0; vert = '0;
    for (int c = 0; c < N + 2; c++) cycle();
    begin
      int first_r, first_l;
      first_r = -1; first_l = -1;
      in_w = 1'b1; in_x = 1'b1;
      for (int c = 1; c <= N + 2; c++) begin
        cycle();
        in_w = 1'b0; in_x = 1'b0;
        if (b_r === 1'b1 && first_r < 0) first_r = c;
        if (b_l === 1'b1 && first_l < 0) first_l = c;
      end
      checks++;
      if (first_r != N) begin
        bad++;
        $display("FAIL R8 in_w->out_r latency actual=%0d expected=%0d", first_r, N);
      end
      checks++;
      if (first_l != N) begin
        bad++;
        $display("FAIL R8 in_x->out_l latency actual=%0d expected=%0d", first_l, N);
      end
    end

    done = 1;
    $display("  test done: total=%0d bad=%0d", checks, bad);
    $finish;
  end

  initial begin
    #(200000 * 5);
    if (!done) begin
      checks++;
      bad++;
      $display("FAIL R1 watchdog actual=running expected=finished");
      $display("  test done: total=%0d bad=%0d", checks, bad);
      $finish;
    end
  end

endmodule